// File: doc/BRIEF.md
# Frame-Rate Cycle-Slip Clock Recovery Loop

This block recovers a local clock that follows an incoming line whose rate sits close to a fixed nominal value. A fast local clock is divided down into a recovered clock enable, and the local clock is split into frames of a fixed nominal number of local cycles. Once per frame, the loop may shorten the frame by one local cycle or lengthen it by one local cycle. Over many frames this moves the average recovered rate by a fraction of a part per million.

An upstream framer supplies a single-cycle pulse, `ref_mark`, at each frame boundary of the line. When that pulse arrives, the loop reads the local frame position and turns it into a signed phase error. A sign-only integrator accumulates that error into a saturating frequency word. A fractional accumulator then turns the size of the word into a rate of one-cycle corrections, and the sign of the word picks the direction. A lock flag reports a sustained run of small phase errors.

With the default parameters, a frame holds 4096 cycles of a 32.768 MHz local clock, which is 125 us. The enable then runs at 2.048 MHz. One cycle per frame is about 244 ppm, one step of the frequency word is about 0.24 ppm, and the word saturates at 838 steps, about 200 ppm.

Top module: `frame_slip_dpll`

## Requirements
- R1: While `rst` is high, and at once when it is raised (asynchronous reset), `freq_word` is 0, `locked` is 0 and `rec_en` is 0. The first local cycle after release is frame position 0.
- R2: `rec_en` is high for one cycle every DIV local cycles, at frame positions DIV-1, 2*DIV-1 and so on. Every frame carries exactly FRAME_LEN/DIV enables. An uncorrected frame is FRAME_LEN local cycles long.
- R3: A `ref_mark` pulse seen at frame position k gives a phase error of k when k < FRAME_LEN/2, and k-FRAME_LEN otherwise.
- R4: A phase error above zero lowers `freq_word` by 1. A phase error below zero raises it by 1. The new value shows one cycle after the pulse. A zero error, or a cycle without `ref_mark`, leaves `freq_word` unchanged.
- R5: `freq_word` (signed, two's complement) saturates at +FREQ_LIM and -FREQ_LIM. Further steps in the same direction leave it at the limit.
- R6: At the last cycle of each frame, the magnitude of `freq_word` is added to an ACC_W-bit accumulator. A carry out of the accumulator corrects the next frame by exactly one local cycle. A positive word shortens that frame to FRAME_LEN-1 cycles, and a negative word lengthens it to FRAME_LEN+1. Only the last recovered period of the frame changes, to DIV-1 or DIV+1 cycles. No frame is corrected by more than one cycle.
- R7: A phase error within ±LOCK_WIN counts as in-window. `locked` rises on the LOCK_N-th consecutive in-window pulse. Any pulse outside the window clears both `locked` and the count. Frames without a pulse neither count nor clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast local clock |
| rst | input | 1 | Asynchronous reset, active high |
| ref_mark | input | 1 | One-cycle pulse at each frame boundary of the line |
| rec_en | output | 1 | Recovered clock enable |
| freq_word | output | FW | Signed frequency offset word, FW = clog2(FREQ_LIM+1)+1 |
| locked | output | 1 | Phase error has stayed small for LOCK_N frames |

## Verification
The hardest condition to reach is a corrected frame where the reference pulse falls near the end of the frame. That is where a shortened frame and a negative phase error meet. The bench finds frame boundaries only by counting enables at the port. It places each reference pulse at a chosen position inside the frame, so it can steer the frequency word in either direction into saturation. The carries that follow produce both shortened and lengthened frames. It also places pulses at 62 and 61, two and three cycles before the nominal end, so they land in frames the loop has already stretched or cut.

// File: rtl/frame_slip_dpll.sv
`timescale 1ns/1ps
module frame_slip_dpll #(
  parameter int DIV       = 16,
  parameter int FRAME_LEN = 4096,
  parameter int ACC_W     = 10,
  parameter int FREQ_LIM  = 838,
  parameter int LOCK_N    = 16,
  parameter int LOCK_WIN  = 2,
  localparam int FW       = $clog2(FREQ_LIM + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_mark,
  output logic                 rec_en,
  output logic signed [FW-1:0] freq_word,
  output logic                 locked
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam int EW    = CNT_W + 1;
  localparam int DIV_W = $clog2(DIV);
  localparam int LK_W  = $clog2(LOCK_N);
  localparam logic signed [FW-1:0] F_MAX = FW'(FREQ_LIM);
  localparam logic signed [FW-1:0] F_MIN = -FW'(FREQ_LIM);
  localparam logic signed [EW-1:0] WIN   = EW'(LOCK_WIN);

  typedef enum logic [1:0] {MODE_NORM, MODE_SKIP, MODE_INS} mode_t;

  logic [CNT_W-1:0]       pos_q;
  mode_t                  mode_q;
  logic [ACC_W-1:0]       acc_q;
  logic [LK_W-1:0]        good_q;
  logic [CNT_W-1:0]       last_pos;
  logic                   frame_end;
  logic signed [EW-1:0]   perr;
  logic                   in_win;
  logic [FW-1:0]          mag;
  logic [ACC_W:0]         sum;

  assign last_pos  = (mode_q == MODE_SKIP) ? CNT_W'(FRAME_LEN - 2) :
                     (mode_q == MODE_INS)  ? CNT_W'(FRAME_LEN)     :
                                             CNT_W'(FRAME_LEN - 1);
  assign frame_end = (pos_q == last_pos);
  assign rec_en    = frame_end ||
                     ((pos_q[DIV_W-1:0] == DIV_W'(DIV - 1)) &&
                      (pos_q < CNT_W'(FRAME_LEN - DIV)));

  assign perr   = (pos_q < CNT_W'(FRAME_LEN / 2)) ? $signed({1'b0, pos_q})
                : $signed({1'b0, pos_q}) - $signed(EW'(FRAME_LEN));
  assign in_win = (perr <= WIN) && (perr >= -WIN);

  assign mag = freq_word[FW-1] ? FW'(-freq_word) : FW'(freq_word);
  assign sum = {1'b0, acc_q} + (ACC_W + 1)'(mag);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pos_q  <= '0;
      mode_q <= MODE_NORM;
      acc_q  <= '0;
    end else if (frame_end) begin
      pos_q  <= '0;
      acc_q  <= sum[ACC_W-1:0];
      mode_q <= !sum[ACC_W] ? MODE_NORM : (freq_word[FW-1] ? MODE_INS : MODE_SKIP);
    end else begin
      pos_q  <= pos_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      freq_word <= '0;
    else if (ref_mark && perr[EW-1] && freq_word != F_MAX)
      freq_word <= freq_word + FW'(1);
    else if (ref_mark && !perr[EW-1] && perr != '0 && freq_word != F_MIN)
      freq_word <= freq_word - FW'(1);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      good_q <= '0;
      locked <= 1'b0;
    end else if (ref_mark) begin
      if (!in_win) begin
        good_q <= '0;
        locked <= 1'b0;
      end else if (good_q == LK_W'(LOCK_N - 1)) begin
        locked <= 1'b1;
      end else begin
        good_q <= good_q + LK_W'(1);
      end
    end
  end

  // R5
  freq_range_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_word <= F_MAX) && (freq_word >= F_MIN));

  // R4
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_mark |=> $stable(freq_word));

  // R2
  enable_gap_chk: assert property (@(posedge clk) disable iff (rst)
    rec_en |=> !rec_en);

  // R6
  zero_word_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && freq_word == '0) |=> (mode_q == MODE_NORM));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_mark |=> $stable(locked));

  // R7
  lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_mark && !in_win) |=> !locked);
endmodule

// File: tb/frame_slip_dpll_bench.sv
`timescale 1ns/1ps
module frame_slip_dpll_bench;
  localparam int DIV = 4, FL = 64, AW = 4, LIM = 12, LN = 16, LW = 2;
  localparam int FW = $clog2(LIM + 1) + 1;
  localparam int NE = FL / DIV;
  localparam int NV = 8;
  localparam int VEC_FR [NV] = '{20, 6, 20, 20, 4, 18, 3, 1};
  localparam int VEC_K  [NV] = '{0, 5, 60, 3, -1, 2, 62, 61};
  localparam int VEC_F  [NV] = '{0, -6, 12, -8, -8, -12, -9, -8};
  localparam int VEC_L  [NV] = '{1, 0, 0, 0, 0, 1, 1, 0};

  logic clk = 1'b0, rst = 1'b1, ref_mark = 1'b0;
  logic rec_en, locked;
  logic signed [FW-1:0] freq_word;

  frame_slip_dpll #(.DIV(DIV), .FRAME_LEN(FL), .ACC_W(AW), .FREQ_LIM(LIM),
                    .LOCK_N(LN), .LOCK_WIN(LW)) u_frame_slip_dpll (
    .clk(clk), .rst(rst), .ref_mark(ref_mark),
    .rec_en(rec_en), .freq_word(freq_word), .locked(locked));

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  int pos, ecnt, last_en, fm, accm, goodm, explen, pend_e;
  bit lockm, pend, end_prev, ended;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_init();
    pos = 0; ecnt = 0; last_en = -1; fm = 0; accm = 0; goodm = 0;
    explen = FL; lockm = 0; pend = 0; end_prev = 0; ended = 0;
  endtask

  task automatic step(input int k);
    int per, mag;
    @(negedge clk);
    if (pend) begin
      if (pend_e > 0 && fm > -LIM) fm--;
      else if (pend_e < 0 && fm < LIM) fm++;
      if (pend_e <= LW && pend_e >= -LW) begin
        if (goodm == LN - 1) lockm = 1; else goodm++;
      end else begin
        goodm = 0; lockm = 0;
      end
      pend = 0;
    end
    pos = end_prev ? 0 : pos + 1;
    ended = 0;
    if (rec_en) begin
      per = pos - last_en;
      ecnt++;
      if (ecnt == NE) begin
        ended = 1;
        chk(pos + 1 == explen, "R6 frame length", pos + 1, explen);
        chk(per == explen - (FL - DIV), "R6 last period", per, explen - (FL - DIV));
      end else begin
        chk(per == DIV, "R2 enable spacing", per, DIV);
      end
      last_en = pos;
    end else if (pos > FL) begin
      chk(0, "R2 enables per frame", ecnt, NE);
      ended = 1;
    end
    if (ended) begin
      chk(int'(freq_word) == fm, "R4 frequency word", int'(freq_word), fm);
      chk(locked == lockm, "R7 lock flag", int'(locked), int'(lockm));
      mag = (fm < 0) ? -fm : fm;
      if (accm + mag >= 2 ** AW) begin
        accm = accm + mag - 2 ** AW;
        explen = (fm > 0) ? FL - 1 : FL + 1;
      end else begin
        accm = accm + mag;
        explen = FL;
      end
      ecnt = 0;
      last_en = -1;
    end
    end_prev = ended;
    if (k >= 0 && pos == k) begin
      ref_mark = 1'b1;
      pend = 1;
      pend_e = (k < FL / 2) ? k : k - FL;
    end else begin
      ref_mark = 1'b0;
    end
  endtask

  task automatic run_frame(input int k);
    do step(k); while (!ended);
  endtask

  initial begin
    #4_000_000;
    errs++; checks++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(freq_word == '0, "R1 reset word", int'(freq_word), 0);
    chk(locked == 1'b0, "R1 reset lock", int'(locked), 0);
    chk(rec_en == 1'b0, "R1 reset enable", int'(rec_en), 0);
    rst = 1'b0;
    model_init();

    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < VEC_FR[v]; f++) run_frame(VEC_K[v]);
      // R3 R5 R7: end-of-vector word and lock against table
      chk(int'(freq_word) == VEC_F[v], "R3/R5 vector word", int'(freq_word), VEC_F[v]);
      chk(int'(locked) == VEC_L[v], "R7 vector lock", int'(locked), VEC_L[v]);
    end

    @(negedge clk);
    ref_mark = 1'b0;
    rst = 1'b1;
    #2;
    chk(freq_word == '0, "R1 async reset word", int'(freq_word), 0);
    chk(locked == 1'b0, "R1 async reset lock", int'(locked), 0);
    @(negedge clk);
    rst = 1'b0;
    model_init();
    run_frame(-1);
    run_frame(-1);
    chk(freq_word == '0, "R4 no pulse keeps word", int'(freq_word), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule